// File: doc/BRIEF.md
# Serial ROM Identifier CRC-8 Checker

This block checks a 64-bit device identifier while it is shifted in one bit at a time from a single-wire bus. The bits arrive least significant first. The low 56 bits are the identifier body. The top byte is a check value stored in true form. Each bit that is qualified by a strobe passes through a reflected serial CRC-8 generator with polynomial x^8 + x^5 + x^4 + 1. The generator starts from zero.

All 64 bits pass through the generator. A correct identifier therefore leaves a zero remainder, and the block raises its pass flag on that condition. A done flag marks the verdict. Done and pass then hold, and further bits are ignored until a clear starts the next frame.

A bus controller uses the block as follows. It pulses the clear before a ROM read, strobes in the bits as it samples them, and waits for done. It can also read the running CRC after 56 bits to see the computed check byte.

Top module: `romid_crc8_chk`

## Requirements
- R1: After reset, crc_o is 0x00 and done_o and pass_o are low.
- R2: Each bit accepted while bit_vld_i is high updates crc_o one clock later as follows: fb = crc[0] XOR bit, then crc = (crc >> 1) XOR (fb ? 0x8C : 0x00). Bits enter least significant first. After the first 56 bits of a frame, crc_o equals the CRC-8 of those 56 bits.
- R3: In a cycle with bit_vld_i and clr_i both low, crc_o, done_o and pass_o keep their values.
- R4: done_o rises in the cycle after the 64th accepted bit of a frame, and not before.
- R5: When done_o rises, pass_o is high exactly when the 64-bit remainder is zero. That is the case when bits 63..56 equal the CRC of bits 55..0, taken without inversion. crc_o then reads 0x00.
- R6: A frame whose top byte does not match the CRC of its body, including any single flipped bit, ends with done_o high and pass_o low.
- R7: Once done_o is high, further strobed bits have no effect: crc_o, done_o and pass_o hold until a clear.
- R8: clr_i returns crc_o to 0x00 and clears the bit count, done_o and pass_o on the next clock. A bit strobed in the same cycle as clr_i is discarded.
- R9: pass_o is never high while done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous frame clear |
| bit_vld_i | input | 1 | Qualifies bit_i for this cycle |
| bit_i | input | 1 | Serial identifier bit, LSB first |
| crc_o | output | 8 | Running CRC register |
| done_o | output | 1 | All 64 bits received |
| pass_o | output | 1 | Identifier check passed, valid with done_o |

## Verification
Clearing and bit acceptance can fall in the same cycle. The bench provokes this by holding clr_i and bit_vld_i high together in the middle of a frame, with bit_i set to 1. It judges the result in two ways. crc_o and done_o must read zero on the next clock. A complete, correct identifier sent afterwards must then produce pass. If the stray bit had been counted or shifted in, the frame would be misaligned and would fail.

// File: rtl/romid_crc_pkg.sv
package romid_crc_pkg;
   localparam int          ROMID_FRAME_BITS = 64;
   localparam int          ROMID_BODY_BITS  = 56;
   localparam int          ROMID_CRC_W      = 8;
   // x^8 + x^5 + x^4 + 1, reflected and normal feedback constants
   localparam logic [7:0]  ROMID_POLY_REFL  = 8'h8C;
   localparam logic [7:0]  ROMID_POLY_NORM  = 8'h31;

   typedef enum logic {
      SHIFT_MSB_FIRST = 1'b0,
      SHIFT_LSB_FIRST = 1'b1
   } shift_order_e;
endpackage

// File: rtl/romid_crc_shift.sv
module romid_crc_shift #(
   parameter int                          CRC_W = 8,
   parameter logic [CRC_W-1:0]            POLY  = 8'h8C,
   parameter romid_crc_pkg::shift_order_e ORDER = romid_crc_pkg::SHIFT_LSB_FIRST
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o,
   output logic             nxt_zero_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;
   logic             fb;

   generate
      if (ORDER == romid_crc_pkg::SHIFT_LSB_FIRST) begin : g_refl
         always_comb begin
            fb      = crc_q[0] ^ bit_i;
            crc_nxt = (crc_q >> 1) ^ (fb ? POLY : '0);
         end
      end else begin : g_norm
         always_comb begin
            fb      = crc_q[CRC_W-1] ^ bit_i;
            crc_nxt = (crc_q << 1) ^ (fb ? POLY : '0);
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     crc_q <= '0;
      else if (clr_i)  crc_q <= '0;
      else if (en_i)   crc_q <= crc_nxt;
   end

   assign crc_o      = crc_q;
   assign nxt_zero_o = (crc_nxt == '0);
endmodule

// File: rtl/romid_bit_count.sv
module romid_bit_count #(
   parameter int FRAME_BITS = 64,
   localparam int CNT_W     = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic at_last_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign at_last_o = (cnt_q == LAST);
endmodule

// File: rtl/romid_verdict.sv
module romid_verdict (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic final_i,
   input  logic zero_i,
   output logic done_o,
   output logic pass_o
);
   logic done_q, pass_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else if (clr_i) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else if (final_i) begin
         done_q <= 1'b1;
         pass_q <= zero_i;
      end
   end

   assign done_o = done_q;
   assign pass_o = pass_q;
endmodule

// File: rtl/romid_crc8_chk.sv
module romid_crc8_chk #(
   parameter int CRC_W      = romid_crc_pkg::ROMID_CRC_W,
   parameter int BODY_BITS  = romid_crc_pkg::ROMID_BODY_BITS,
   parameter int FRAME_BITS = romid_crc_pkg::ROMID_FRAME_BITS,
   parameter romid_crc_pkg::shift_order_e ORDER = romid_crc_pkg::SHIFT_LSB_FIRST
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o,
   output logic             done_o,
   output logic             pass_o
);
   localparam logic [CRC_W-1:0] POLY =
      (ORDER == romid_crc_pkg::SHIFT_LSB_FIRST) ? CRC_W'(romid_crc_pkg::ROMID_POLY_REFL)
                                                : CRC_W'(romid_crc_pkg::ROMID_POLY_NORM);

   generate
      if (BODY_BITS + CRC_W != FRAME_BITS) begin : g_bad_frame
         $error("frame length must equal body plus check width");
      end
      if (CRC_W != 8) begin : g_bad_width
         $error("feedback constants are defined for an 8-bit check only");
      end
   endgenerate

   logic accept, at_last, nxt_zero;

   assign accept = bit_vld_i & ~clr_i & ~done_o;

   romid_crc_shift #(.CRC_W(CRC_W), .POLY(POLY), .ORDER(ORDER)) u_shift (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .en_i       (accept),
      .bit_i      (bit_i),
      .crc_o      (crc_o),
      .nxt_zero_o (nxt_zero)
   );

   romid_bit_count #(.FRAME_BITS(FRAME_BITS)) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .en_i      (accept),
      .at_last_o (at_last)
   );

   romid_verdict u_verdict (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .final_i (accept & at_last),
      .zero_i  (nxt_zero),
      .done_o  (done_o),
      .pass_o  (pass_o)
   );
endmodule

// File: rtl/romid_crc8_props.sv
module romid_crc8_props #(
   parameter int CRC_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clr_i,
   input logic             bit_vld_i,
   input logic [CRC_W-1:0] crc_o,
   input logic             done_o,
   input logic             pass_o
);
   assert_pass_needs_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pass_o |-> done_o);

   assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !bit_vld_i) |=> ($stable(crc_o) && $stable(done_o) && $stable(pass_o)));

   assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !clr_i) |=> (done_o && $stable(crc_o) && $stable(pass_o)));

   assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (crc_o == '0 && !done_o && !pass_o));

   assert_done_on_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> ($past(bit_vld_i) && !$past(clr_i)));

   assert_pass_zero_rem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && pass_o) |-> (crc_o == '0));
endmodule

bind romid_crc8_chk romid_crc8_props #(.CRC_W(CRC_W)) u_props (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .clr_i     (clr_i),
   .bit_vld_i (bit_vld_i),
   .crc_o     (crc_o),
   .done_o    (done_o),
   .pass_o    (pass_o)
);

// File: tb/tb_romid_crc8_chk.sv
module tb_romid_crc8_chk;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       clr_i = 1'b0;
   logic       bit_vld_i = 1'b0;
   logic       bit_i = 1'b0;
   logic [7:0] crc_o;
   logic       done_o, pass_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk_i = ~clk_i;

   romid_crc8_chk dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .bit_vld_i(bit_vld_i), .bit_i(bit_i),
      .crc_o(crc_o), .done_o(done_o), .pass_o(pass_o)
   );

   function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < n; i++) begin
         logic f = c[0] ^ v[i];
         c = {1'b0, c[7:1]};
         if (f) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   function automatic logic [63:0] make_id(input int seed);
      logic [55:0] body;
      body = 56'(64'(seed + 1) * 64'h9E3779B97F4A7C15) ^ 56'(seed * 977);
      return {ref_crc({8'h00, body}, 56), body};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic v, input logic b);
      @(negedge clk_i);
      clr_i = c; bit_vld_i = v; bit_i = b;
      @(posedge clk_i);
      #2;
   endtask

   // Sends a frame after a clear; optional idle gaps; checks R2/R3/R4 en route
   task automatic send_frame(input logic [63:0] id, input bit gaps, input bit inspect);
      step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 64; i++) begin
         if (inspect && i == 63)
            check(done_o == 1'b0, "R4 done early", done_o, 0);
         step(1'b0, 1'b1, id[i]);
         if (inspect && i == 55)
            check(crc_o == ref_crc(id, 56), "R2 crc after body", crc_o, ref_crc(id, 56));
         if (gaps) begin
            logic [7:0] held = crc_o;
            step(1'b0, 1'b0, ~id[i]);
            if (inspect && i % 8 == 3)
               check(crc_o == held, "R3 idle hold", crc_o, held);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk_i);
      #2;
      check(crc_o == 8'h00 && !done_o && !pass_o, "R1 reset state",
            {crc_o, done_o, pass_o}, 0);
      @(negedge clk_i) rst_ni = 1'b1;

      // R2 R4 R5: good identifiers, with and without gaps
      for (int k = 0; k < 16; k++) begin
         logic [63:0] id = make_id(k);
         send_frame(id, k[0], 1'b1);
         check(done_o && pass_o, "R5 good id pass", {done_o, pass_o}, 2'b11);
         check(crc_o == 8'h00, "R5 zero remainder", crc_o, 0);
      end

      // R6: every single-bit corruption must fail
      for (int p = 0; p < 64; p++) begin
         logic [63:0] id = make_id(100 + p) ^ (64'd1 << p);
         send_frame(id, 1'b0, 1'b0);
         check(done_o && !pass_o, "R6 flipped bit fails", {done_o, pass_o}, 2'b10);
         check(!(pass_o && !done_o), "R9 pass without done", pass_o, 0);
      end

      // R5 R6: stored byte inverted is not accepted
      begin
         logic [63:0] id = make_id(7);
         id[63:56] = ~id[63:56];
         send_frame(id, 1'b0, 1'b0);
         check(done_o && !pass_o, "R5 inverted check byte", {done_o, pass_o}, 2'b10);
      end

      // R7: bits after done are ignored
      begin
         logic [63:0] id = make_id(3);
         send_frame(id, 1'b0, 1'b0);
         for (int j = 0; j < 10; j++) step(1'b0, 1'b1, j[0]);
         check(done_o && pass_o && crc_o == 8'h00, "R7 extra bits ignored",
               {crc_o, done_o, pass_o}, 10'b0000000011);
         send_frame(make_id(4) ^ 64'h1, 1'b0, 1'b0);
         for (int j = 0; j < 10; j++) step(1'b0, 1'b1, ~j[0]);
         check(done_o && !pass_o, "R7 failed verdict held", {done_o, pass_o}, 2'b10);
      end

      // R8: clear together with a strobed bit mid-frame
      begin
         logic [63:0] id = make_id(21);
         step(1'b1, 1'b0, 1'b0);
         for (int i = 0; i < 20; i++) step(1'b0, 1'b1, id[i]);
         step(1'b1, 1'b1, 1'b1);
         check(crc_o == 8'h00 && !done_o && !pass_o, "R8 clear with bit",
               {crc_o, done_o, pass_o}, 0);
         for (int i = 0; i < 64; i++) step(1'b0, 1'b1, id[i]);
         check(done_o && pass_o, "R8 strobed bit discarded", {done_o, pass_o}, 2'b11);
         step(1'b1, 1'b0, 1'b0);
         check(!done_o && !pass_o && crc_o == 8'h00, "R8 clear after done",
               {crc_o, done_o, pass_o}, 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule